// File: doc/BRIEF.md
# Two-channel stopped-clock DAC feeder from I2S

This block takes a standard I2S stream and produces the serial feeds for a pair of 24-bit mono DACs that load their parallel register on the falling edge of a latch line. The inputs are the I2S bit clock, word select and serial data. The outputs are one bit clock per DAC, a single latch-enable and a single data line, and both DACs share the latch and data lines. The whole block runs on a system clock that is several times faster than the I2S bit clock. It oversamples the three I2S inputs through two-stage synchronisers. It builds every output edge from registers, so no output clock is gated combinationally.

Each I2S slot is collected MSB first. The word is cut to its 24 most significant bits, or zero-filled in the low bits when the slot is narrower than 24 bits. After the left and right words of one frame have both arrived, the block replays them as a burst. The burst starts with 24 pulses on the left DAC clock and then 24 pulses on the right DAC clock, MSB first, so the LSB is the last bit each DAC shifts in. The latch goes high after the first right-channel pulse. It falls after the last right-channel pulse, and both DACs take their new words at that falling edge. Between bursts both DAC clocks stay stopped.

Top module: `i2s_split_dac`

## Requirements
- R1: While synchronous reset `rst` is high, and after it until the first output burst, both DAC clocks are low and `dac_le` is high.
- R2: The left word (the I2S slot with word select low) reaches the left DAC as exactly the rising edges of `dac_bclk_l` in one burst. The MSB comes first and the LSB is the last bit before `dac_le` falls.
- R3: The right word (the slot with word select high) reaches the right DAC the same way on `dac_bclk_r`. The right burst follows the left burst of the same frame.
- R4: `dac_le` rises only on the falling edge of the first right-channel pulse of a burst. It falls only when both clocks are low, at least one output half-period after the last right pulse. It stays low through every left pulse of the next burst.
- R5: `dac_bclk_l` and `dac_bclk_r` are never high at the same time.
- R6: `dac_sd` changes only while both DAC clocks are low.
- R7: In slots wider than 24 bits, the bits after the first 24 are discarded.
- R8: In slots narrower than 24 bits, the missing low bits are sent as zeros.
- R9: Every burst carries exactly 24 pulses on each DAC clock.
- R10: A frame is forwarded only if its left slot began after a word-select edge seen since reset. The first, partial frame after reset produces no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the I2S bit clock |
| rst | input | 1 | Synchronous reset, active high |
| i2s_bclk | input | 1 | I2S bit clock (sampled) |
| i2s_ws | input | 1 | I2S word select, low = left |
| i2s_sd | input | 1 | I2S serial data, MSB first |
| dac_bclk_l | output | 1 | Left DAC bit clock, stopped between bursts |
| dac_bclk_r | output | 1 | Right DAC bit clock, stopped between bursts |
| dac_le | output | 1 | Shared latch-enable, DACs load on its falling edge |
| dac_sd | output | 1 | Shared serial data, valid on rising DAC clock edges |

## Verification
The timing that is hardest to provoke from the ports is the restart after a stop. This covers the latch going low at the end of one burst and staying low through the first pulses of the next burst, and also the startup path where the first frame must be dropped. The stimulus sends back-to-back frames of mixed slot widths, so latch falls and clock restarts follow each other closely. Both at power-up and after a reset in mid-run, it begins with a junk frame and then checks that nothing reaches the DACs until a whole left-then-right pair has arrived.

// File: rtl/i2s_split_dac.sv
module i2s_split_dac #(
  parameter int WORD_W  = 24,
  parameter int OUT_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic i2s_bclk,
  input  logic i2s_ws,
  input  logic i2s_sd,
  output logic dac_bclk_l,
  output logic dac_bclk_r,
  output logic dac_le,
  output logic dac_sd
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam int PW = $clog2(2 * WORD_W);
  localparam int DW = (OUT_DIV > 1) ? $clog2(OUT_DIV) : 1;

  typedef enum logic [1:0] {IDLE, SHIFT, TAIL} st_t;

  logic [2:0] bclk_q;
  logic [1:0] ws_q, sd_q;
  logic       rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= '0;
      ws_q   <= '0;
      sd_q   <= '0;
    end else begin
      bclk_q <= {bclk_q[1:0], i2s_bclk};
      ws_q   <= {ws_q[0], i2s_ws};
      sd_q   <= {sd_q[0], i2s_sd};
    end
  end

  assign rise = bclk_q[1] & ~bclk_q[2];

  logic [WORD_W-1:0] sh_in, sh_app, aligned, l_word, l_hold, r_hold;
  logic [CW-1:0]     cnt, n_app;
  logic              ws_prev, synced, have_l, frame_rdy;

  always_comb begin
    sh_app  = (cnt < CW'(WORD_W)) ? {sh_in[WORD_W-2:0], sd_q[1]} : sh_in;
    n_app   = (cnt < CW'(WORD_W)) ? cnt + 1'b1 : CW'(WORD_W);
    aligned = sh_app << (CW'(WORD_W) - n_app);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_in     <= '0;
      cnt       <= '0;
      ws_prev   <= 1'b0;
      synced    <= 1'b0;
      have_l    <= 1'b0;
      frame_rdy <= 1'b0;
      l_word    <= '0;
      l_hold    <= '0;
      r_hold    <= '0;
    end else begin
      frame_rdy <= 1'b0;
      if (rise) begin
        ws_prev <= ws_q[1];
        if (ws_q[1] != ws_prev) begin
          sh_in  <= '0;
          cnt    <= '0;
          synced <= 1'b1;
          if (!ws_prev) begin
            l_word <= aligned;
            have_l <= synced;
          end else begin
            have_l <= 1'b0;
            if (have_l) begin
              l_hold    <= l_word;
              r_hold    <= aligned;
              frame_rdy <= 1'b1;
            end
          end
        end else if (cnt < CW'(WORD_W)) begin
          sh_in <= sh_app;
          cnt   <= n_app;
        end
      end
    end
  end

  st_t                state;
  logic [2*WORD_W-1:0] osh;
  logic [PW-1:0]       pos;
  logic [DW-1:0]       div;
  logic                half, pend, tick;

  assign tick   = (div == DW'(OUT_DIV - 1));
  assign dac_sd = osh[2*WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= IDLE;
      osh        <= '0;
      pos        <= '0;
      div        <= '0;
      half       <= 1'b0;
      pend       <= 1'b0;
      dac_bclk_l <= 1'b0;
      dac_bclk_r <= 1'b0;
      dac_le     <= 1'b1;
    end else begin
      pend <= frame_rdy | (pend & (state != IDLE));
      if (state != IDLE) div <= tick ? '0 : div + 1'b1;
      case (state)
        IDLE: if (pend) begin
          osh   <= {l_hold, r_hold};
          pos   <= '0;
          half  <= 1'b0;
          div   <= '0;
          state <= SHIFT;
        end
        SHIFT: if (tick) begin
          if (!half) begin
            half <= 1'b1;
            if (pos < PW'(WORD_W)) dac_bclk_l <= 1'b1;
            else                   dac_bclk_r <= 1'b1;
          end else begin
            half       <= 1'b0;
            dac_bclk_l <= 1'b0;
            dac_bclk_r <= 1'b0;
            if (pos == PW'(WORD_W)) dac_le <= 1'b1;
            if (pos == PW'(2*WORD_W-1)) state <= TAIL;
            else begin
              pos <= pos + 1'b1;
              osh <= {osh[2*WORD_W-2:0], 1'b0};
            end
          end
        end
        TAIL: if (tick) begin
          dac_le <= 1'b0;
          state  <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!dac_bclk_l && !dac_bclk_r && dac_le));

  p_one_clock_r5: assert property (@(posedge clk) disable iff (rst)
    !(dac_bclk_l && dac_bclk_r));

  p_sd_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (dac_bclk_l || dac_bclk_r) |-> $stable(dac_sd));

  p_le_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_le) |-> $fell(dac_bclk_r));

  p_le_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_le) |-> (!dac_bclk_l && !dac_bclk_r && $past(!dac_bclk_r)));
endmodule

// File: tb/i2s_split_dac_bench.sv
module i2s_split_dac_bench;
  logic clk = 1'b0;
  logic rst, i2s_bclk, i2s_ws, i2s_sd;
  logic dac_bclk_l, dac_bclk_r, dac_le, dac_sd;

  always #5 clk = ~clk;

  i2s_split_dac u_i2s_split_dac (
    .clk(clk), .rst(rst), .i2s_bclk(i2s_bclk), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd),
    .dac_bclk_l(dac_bclk_l), .dac_bclk_r(dac_bclk_r), .dac_le(dac_le), .dac_sd(dac_sd)
  );

  // {left 32b MSB-aligned, right 32b MSB-aligned, slot width}
  localparam logic [71:0] VEC [6] = '{
    {32'h12345678, 32'h9ABCDEF0, 8'd32},
    {32'h80000000, 32'h7FFFFF00, 8'd24},
    {32'hFFFF0000, 32'hA5A50000, 8'd16},
    {32'h00000100, 32'hFFFFFFFF, 8'd32},
    {32'hC3C3C000, 32'h5A5A5FFF, 8'd20},
    {32'h00000000, 32'h00000100, 8'd24}
  };

  int n_checks = 0, n_err = 0;
  logic [23:0] exp_l [16], exp_r [16];
  string tag_l [16], tag_r [16];
  int n_exp = 0, latches = 0;
  int nl = 0, nr = 0, v_both = 0, v_sd = 0, v_le = 0;
  logic [23:0] shl = '0, shr = '0;
  logic pl = 0, pr = 0, ple = 1, psd = 0, armed = 0;

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expect24(input logic [31:0] v, input int s);
    logic [23:0] t = v[31:8];
    if (s < 24) t = (t >> (24 - s)) << (24 - s);
    return t;
  endfunction

  task automatic push(input logic [31:0] l, input logic [31:0] r, input int s, input string tl, input string tr);
    exp_l[n_exp] = expect24(l, s);
    exp_r[n_exp] = expect24(r, s);
    tag_l[n_exp] = tl;
    tag_r[n_exp] = tr;
    n_exp++;
  endtask

  task automatic drive_bit(input logic ws, input logic sd);
    @(negedge clk);
    i2s_bclk = 1'b0;
    i2s_ws   = ws;
    i2s_sd   = sd;
    repeat (3) @(negedge clk);
    i2s_bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [31:0] l, input logic [31:0] r, input int s);
    for (int ch = 0; ch < 2; ch++) begin
      logic [31:0] w = (ch == 0) ? l : r;
      for (int b = 0; b < s; b++)
        drive_bit((b == s - 1) ? (ch == 0) : (ch == 1), w[31-b]);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      nl = 0; nr = 0; armed = 0;
      pl = 0; pr = 0; ple = 1; psd = dac_sd;
    end else begin
      if (dac_bclk_l && dac_bclk_r) v_both++;
      if ((dac_bclk_l || dac_bclk_r) && dac_sd != psd) v_sd++;
      if (dac_bclk_l && !pl) begin
        shl = {shl[22:0], dac_sd};
        nl++;
        if (armed && dac_le) v_le++;
      end
      if (dac_bclk_r && !pr) begin
        shr = {shr[22:0], dac_sd};
        nr++;
      end
      if (dac_le && !ple)
        check(nr == 1 && !dac_bclk_r, "R4 latch rise after first right pulse", 24'(nr), 24'd1);
      if (!dac_le && ple) begin
        check(nl == 24, "R9 left pulse count", 24'(nl), 24'd24);
        check(nr == 24, "R9 right pulse count", 24'(nr), 24'd24);
        if (latches < n_exp) begin
          check(shl == exp_l[latches], tag_l[latches], shl, exp_l[latches]);
          check(shr == exp_r[latches], tag_r[latches], shr, exp_r[latches]);
        end else
          check(1'b0, "R10 unexpected latch", 24'(latches), 24'(n_exp));
        latches++;
        nl = 0; nr = 0; armed = 1;
      end
      pl = dac_bclk_l; pr = dac_bclk_r; ple = dac_le; psd = dac_sd;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 24'd0, 24'd1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; i2s_bclk = 1'b0; i2s_ws = 1'b0; i2s_sd = 1'b0;
    repeat (5) @(negedge clk);
    check(dac_le == 1'b1, "R1 latch high in reset", 24'(dac_le), 24'd1);
    check(!dac_bclk_l && !dac_bclk_r, "R1 clocks stopped in reset", {22'd0, dac_bclk_l, dac_bclk_r}, 24'd0);
    rst = 1'b0;

    send_frame(32'hDEADBEEF, 32'hCAFEF00D, 32);
    repeat (300) @(negedge clk);
    check(nl == 0 && nr == 0 && latches == 0, "R10 partial first frame dropped", 24'(nl + nr + latches), 24'd0);
    check(dac_le == 1'b1, "R1 latch high before first burst", 24'(dac_le), 24'd1);

    for (int i = 0; i < 6; i++) begin
      push(VEC[i][71:40], VEC[i][39:8], int'(VEC[i][7:0]), "R2 left word", "R3 right word");
      send_frame(VEC[i][71:40], VEC[i][39:8], int'(VEC[i][7:0]));
    end
    repeat (400) @(negedge clk);
    check(latches == 6, "R2 latch events after table", 24'(latches), 24'd6);

    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(dac_le && !dac_bclk_l && !dac_bclk_r, "R1 mid-run reset idle", {21'd0, dac_le, dac_bclk_l, dac_bclk_r}, 24'h4);
    rst = 1'b0;
    send_frame(32'h11111111, 32'h22222222, 24);
    repeat (300) @(negedge clk);
    check(latches == 6, "R10 frame after reset dropped", 24'(latches), 24'd6);

    push(32'h000000FF, 32'h123456AB, 32, "R7 left extra bits discarded", "R7 right extra bits discarded");
    send_frame(32'h000000FF, 32'h123456AB, 32);
    push(32'hFFFF8000, 32'hAAAA8000, 17, "R8 left zero padded", "R8 right zero padded");
    send_frame(32'hFFFF8000, 32'hAAAA8000, 17);
    repeat (400) @(negedge clk);
    check(latches == 8, "R9 total latch events", 24'(latches), 24'd8);

    check(v_both == 0, "R5 both clocks high", 24'(v_both), 24'd0);
    check(v_sd == 0, "R6 data moved while clock high", 24'(v_sd), 24'd0);
    check(v_le == 0, "R4 latch high during left pulses", 24'(v_le), 24'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule